// File: doc/BRIEF.md
# Equal-Frequency Link Phase Synchronizer

This block joins two neighbouring router tiles whose clocks share one frequency but have an unknown, fixed phase relation. The sending tile writes one slot per transmit clock into a four-slot ring. Each slot holds a flit and a flag saying whether the flit is real. The receiving tile reads the ring in its own clock domain, one slot per receive clock. The read strobe starts a programmable number of cycles (0, 1 or 2) after reset release, so the read can be placed away from the phase window where a slot is being rewritten.

Both pointers start together from one shared asynchronous reset. That reset is released into each domain through its own two-stage synchronizer. After start-up both pointers advance on every edge of their own clock, so the distance between them never changes. This means no pointer has to cross a clock boundary, and no full or empty state has to be computed. The lead setting is static: it is chosen once per link from the measured phase and takes effect at the next reset release.

Top module: `meso_link_sync`

## Requirements
- R1: While `arst_n` is low, `rx_valid` and `rx_data` are 0, and they drop to 0 as soon as reset asserts.
- R2: The write ring starts on the third `tx_clk` rising edge after `arst_n` rises. It fills slot 0 on that edge and then moves by one slot on every `tx_clk` edge. Flits offered on the first two edges after release are dropped and never reach the output.
- R3: The read strobe fires first on `rx_clk` rising edge 3+D after release, where D is the effective lead. From then on it fires on every edge. Each strobe loads the addressed slot into the registered outputs and moves the read pointer from slot 0 by one.
- R4: Every flit that the ring accepts comes out once, in the order it was sent, with its data unchanged. This holds for any receive clock phase and for idle gaps between flits.
- R5: Within one run, every flit has the same latency. Latency is the number of `rx_clk` rising edges after the `tx_clk` edge that captured the flit, up to and including the edge that loads it.
- R6: Suppose release comes 0.5 ns after a `tx_clk` edge and the `rx_clk` lag is between 0.5 ns and one period. Then the latency is 4 for D=0, 1 for D=1 and 2 for D=2.
- R7: `lead_sel` value 3 behaves as 2: the lead is clamped to 2.
- R8: An idle transmit cycle (`tx_valid` low) reaches the output as `rx_valid` low with `rx_data` 0.
- R9: If reset asserts during traffic, flits in flight are discarded. After the next release the link starts again from R2 and R3 and emits nothing from before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sending tile clock |
| tx_valid | input | 1 | Flit on `tx_data` is real this cycle |
| tx_data | input | DATA_W | Flit from the sending tile |
| rx_clk | input | 1 | Receiving tile clock, same frequency, any phase |
| arst_n | input | 1 | Shared asynchronous reset, active low |
| lead_sel | input | 2 | Read strobe lead in receive cycles (0..2, 3 clamps to 2) |
| rx_valid | output | 1 | Flit on `rx_data` is real this cycle |
| rx_data | output | DATA_W | Flit in the receive domain |

## Verification
The receive clock is swept across five phase lags within one period, and each lead setting is run at several of those lags. Continuous streams check that latency does not depend on phase. Streams with idle gaps show that empty slots are carried as empty and are not skipped or merged. A count of receive edges per flit tells apart the three lead settings and the clamped value. Flits offered just after release, and a reset during traffic, check that start-up flits and flits in flight never appear at the output.

// File: rtl/meso_sync_pkg.sv
package meso_sync_pkg;

  typedef enum logic {RX_LEAD = 1'b0, RX_RUN = 1'b1} rx_state_e;

  // Next slot on a ring of the given depth
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // Lead setting limited to the supported maximum
  function automatic int unsigned clamp_lead(input int unsigned sel, input int unsigned max_lead);
    return (sel > max_lead) ? max_lead : sel;
  endfunction

endpackage

// File: rtl/meso_rst_sync.sv
module meso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];

  // R2 R3: released output never falls without the raw reset falling
  assert_release_only_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $past(rst_n_sync) |-> rst_n_sync);
endmodule

// File: rtl/meso_tx_ring.sv
module meso_tx_ring
  import meso_sync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  output logic [DEPTH-1:0]              slot_vld,
  output logic [DEPTH-1:0][DATA_W-1:0]  slot_dat
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] wptr;
  logic [DEPTH-1:0] wr_sel;
  logic [DATA_W-1:0] wr_word;

  assign wr_word = in_valid ? in_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else        wptr <= PTR_W'(ring_next(32'(wptr), DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_sel[i] = (wptr == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[i] <= 1'b0;
        slot_dat[i] <= '0;
      end else if (wr_sel[i]) begin
        slot_vld[i] <= in_valid;
        slot_dat[i] <= wr_word;
      end
    end

    // R8: an empty slot never carries data
    assert_empty_slot_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[i] |-> slot_dat[i] == '0);
  end

  // R2: exactly one slot is targeted per cycle
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_sel) == 1);

  // R2: pointer moves on every edge once released
  assert_wptr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wptr != $past(wptr));
endmodule

// File: rtl/meso_rx_strobe.sv
module meso_rx_strobe
  import meso_sync_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 4,
  parameter int SEL_W    = 2,
  parameter int MAX_LEAD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              lead_sel,
  input  logic [DEPTH-1:0]              slot_vld,
  input  logic [DEPTH-1:0][DATA_W-1:0]  slot_dat,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(MAX_LEAD + 1);

  rx_state_e        st;
  logic [CNT_W-1:0] lead_cnt;
  logic [CNT_W-1:0] lead_eff;
  logic [PTR_W-1:0] rptr;
  logic             strobe;

  assign lead_eff = CNT_W'(clamp_lead(32'(lead_sel), MAX_LEAD));
  assign strobe   = (st == RX_RUN) || (lead_cnt >= lead_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_LEAD;
      lead_cnt <= '0;
    end else if (strobe) begin
      st <= RX_RUN;
    end else begin
      lead_cnt <= lead_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (strobe) begin
      rptr      <= PTR_W'(ring_next(32'(rptr), DEPTH));
      out_valid <= slot_vld[rptr];
      out_data  <= slot_dat[rptr];
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end
  end

  // R3: nothing emerges before the first strobe
  assert_quiet_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_LEAD && !strobe) |=> !out_valid);

  // R3: once running, the pointer moves every edge
  assert_rptr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st) == RX_RUN |-> rptr != $past(rptr));

  // R3: running state is held until reset
  assert_run_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st) == RX_RUN |-> st == RX_RUN);

  // R7: lead counter never exceeds the clamp
  assert_lead_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_cnt <= CNT_W'(MAX_LEAD));

  // R8: idle output carries zero data
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);
endmodule

// File: rtl/meso_link_sync.sv
module meso_link_sync #(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 4,
  parameter int SEL_W    = 2,
  parameter int MAX_LEAD = 2,
  parameter int SYNC_STG = 2
) (
  input  logic              tx_clk,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_clk,
  input  logic              arst_n,
  input  logic [SEL_W-1:0]  lead_sel,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  logic                         tx_rst_n;
  logic                         rx_rst_n;
  logic [DEPTH-1:0]             ring_vld;
  logic [DEPTH-1:0][DATA_W-1:0] ring_dat;

  meso_rst_sync #(.STAGES(SYNC_STG)) u_tx_rst (
    .clk(tx_clk), .arst_n(arst_n), .rst_n_sync(tx_rst_n));

  meso_rst_sync #(.STAGES(SYNC_STG)) u_rx_rst (
    .clk(rx_clk), .arst_n(arst_n), .rst_n_sync(rx_rst_n));

  meso_tx_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(tx_clk), .rst_n(tx_rst_n),
    .in_valid(tx_valid), .in_data(tx_data),
    .slot_vld(ring_vld), .slot_dat(ring_dat));

  meso_rx_strobe #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W),
                   .MAX_LEAD(MAX_LEAD)) u_strobe (
    .clk(rx_clk), .rst_n(rx_rst_n), .lead_sel(lead_sel),
    .slot_vld(ring_vld), .slot_dat(ring_dat),
    .out_valid(rx_valid), .out_data(rx_data));

  // R1: reset holds the output empty
  assert_reset_quiet_R1: assert property (@(posedge rx_clk)
    !arst_n |-> (!rx_valid && rx_data == '0));
endmodule

// File: tb/meso_link_sync_tb.sv
`timescale 1ns/1ps
module meso_link_sync_tb_top;
  localparam int  DW = 32;
  localparam real TP = 8.0;

  logic          tx_clk = 1'b0;
  logic          rx_clk = 1'b0;
  logic          tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          arst_n = 1'b0;
  logic [1:0]    lead_sel = 2'd0;
  logic          rx_valid;
  logic [DW-1:0] rx_data;

  real rx_phase = 1.0;
  int  checks = 0;
  int  failures = 0;
  int  rx_cnt = 0;
  int  got = 0;
  int  exp_latency = 0;
  bit  sb_on = 1'b0;
  bit  mon_on = 1'b0;
  logic [DW-1:0] q_data[$];
  int            q_edge[$];

  meso_link_sync #(.DATA_W(DW)) dut_i (
    .tx_clk(tx_clk), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_clk(rx_clk), .arst_n(arst_n), .lead_sel(lead_sel),
    .rx_valid(rx_valid), .rx_data(rx_data));

  always #(TP/2) tx_clk = ~tx_clk;

  always @(posedge tx_clk) fork
    begin #(rx_phase) rx_clk = 1'b1; #(TP/2) rx_clk = 1'b0; end
  join_none

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Latency from timing alone: write on tx edge 3, first read on rx edge 3+D,
  // same slot revisited every 4 receive edges.
  function automatic int exp_lat(input real phi, input int sel);
    int  d;
    real tw, tr;
    d  = (sel > 2) ? 2 : sel;
    tw = 3.0 * TP;
    tr = phi + (2 + d) * TP;
    while (tr < tw) tr = tr + 4.0 * TP;
    return $rtoi($floor((tr - phi) / TP + 0.001)) - $rtoi($floor((tw - phi) / TP));
  endfunction

  always @(posedge rx_clk) rx_cnt++;

  always @(posedge tx_clk) begin
    if (sb_on && tx_valid) begin
      q_data.push_back(tx_data);
      q_edge.push_back(rx_cnt);
    end
  end

  always @(negedge rx_clk) begin
    if (arst_n && mon_on) begin
      if (rx_valid) begin
        got++;
        if (q_data.size() == 0) begin
          chk(1'b0, "R4 R2 unexpected flit", rx_data, 0);
        end else begin
          logic [DW-1:0] ed;
          int e0;
          ed = q_data.pop_front();
          e0 = q_edge.pop_front();
          chk(rx_data == ed, "R4 data order", rx_data, ed);
          chk(rx_cnt - e0 == exp_latency, "R5 R6 latency", rx_cnt - e0, exp_latency);
        end
      end else begin
        chk(rx_data == '0, "R8 idle data", rx_data, 0);
      end
    end
  end

  task automatic do_reset(input int sel, input real phi);
    mon_on = 1'b0;
    sb_on = 1'b0;
    arst_n = 1'b0;
    tx_valid = 1'b0;
    tx_data = '0;
    repeat (3) @(posedge tx_clk);
    rx_phase = phi;
    lead_sel = 2'(sel);
    exp_latency = exp_lat(phi, sel);
    repeat (3) @(posedge tx_clk);
    q_data.delete();
    q_edge.delete();
    got = 0;
    @(posedge tx_clk);
    #0.5 arst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  // Offer n flits starting at the first accepted edge; gap>0 inserts idles
  task automatic drive(input int n, input int gap, input logic [DW-1:0] seed);
    int sent;
    sent = 0;
    @(posedge tx_clk);
    @(posedge tx_clk);
    sb_on = 1'b1;
    while (sent < n) begin
      @(negedge tx_clk);
      if (gap > 0 && ((sent + rx_cnt) % (gap + 1)) == gap && tx_valid) begin
        tx_valid = 1'b0;
        tx_data = 32'hDEAD_BEEF;
      end else begin
        tx_valid = 1'b1;
        tx_data = seed + DW'(sent * 32'h0101_0003);
        sent++;
      end
    end
    @(negedge tx_clk);
    tx_valid = 1'b0;
    tx_data = '0;
    repeat (12) @(posedge tx_clk);
  endtask

  task automatic t_reset_state();
    arst_n = 1'b0;
    repeat (4) @(posedge tx_clk);
    @(negedge rx_clk);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    chk(rx_data == '0, "R1 reset data", rx_data, 0);
  endtask

  task automatic t_stream(input int sel, input real phi, input int n, input int gap,
                          input logic [DW-1:0] seed);
    do_reset(sel, phi);
    drive(n, gap, seed);
    chk(q_data.size() == 0, "R4 no loss", q_data.size(), 0);
    chk(got == n, "R4 count", got, n);
  endtask

  task automatic t_early_drop();
    do_reset(1, 3.0);
    @(negedge tx_clk);
    tx_valid = 1'b1;
    tx_data = 32'hAAAA_0001;
    @(negedge tx_clk);
    tx_data = 32'hAAAA_0002;
    @(negedge tx_clk);
    tx_valid = 1'b0;
    tx_data = '0;
    repeat (14) @(posedge tx_clk);
    chk(got == 0, "R2 early flits dropped", got, 0);
  endtask

  task automatic t_midrun_reset();
    do_reset(2, 5.5);
    @(posedge tx_clk);
    @(posedge tx_clk);
    sb_on = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge tx_clk);
      tx_valid = 1'b1;
      tx_data = 32'h5000_0000 + DW'(i);
    end
    @(negedge tx_clk);
    mon_on = 1'b0;
    sb_on = 1'b0;
    arst_n = 1'b0;
    tx_valid = 1'b0;
    #0.2;
    chk(rx_valid == 1'b0, "R9 R1 async clear valid", rx_valid, 0);
    chk(rx_data == '0, "R9 R1 async clear data", rx_data, 0);
    q_data.delete();
    q_edge.delete();
    do_reset(1, 5.5);
    drive(6, 0, 32'h6000_0000);
    chk(q_data.size() == 0, "R9 clean restart", q_data.size(), 0);
    chk(got == 6, "R9 restart count", got, 6);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    fork
      begin
        t_reset_state();
        // R6 R3: each lead across a phase sweep
        t_stream(0, 1.0, 10, 0, 32'h1000_0000);
        t_stream(0, 7.0, 10, 0, 32'h1100_0000);
        t_stream(1, 2.5, 10, 0, 32'h1200_0000);
        t_stream(1, 5.5, 10, 0, 32'h1300_0000);
        t_stream(2, 4.0, 10, 0, 32'h1400_0000);
        t_stream(2, 7.0, 10, 0, 32'h1500_0000);
        // R7: setting 3 clamps to 2
        t_stream(3, 2.5, 8, 0, 32'h1600_0000);
        // R4 R8: streams with idle gaps
        t_stream(0, 4.0, 12, 2, 32'h1700_0000);
        t_stream(2, 1.0, 12, 1, 32'h1800_0000);
        t_early_drop();
        t_midrun_reset();
      end
      begin
        while (cyc < 100000) begin
          @(posedge tx_clk);
          cyc++;
        end
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule